// File: doc/BRIEF.md
# DMA-Aware Register Window Decoder

This block sits on the address path between a processor and a DMA engine that can take the bus away from it. Each cycle it picks the outgoing bus address from one of four requesters: the processor, an audio-sample fetcher, a sprite-copy reader or a sprite-copy writer. It also decides whether a small window of internal registers is live. That enable is worked out from the processor's own address only. It does not use the address that actually goes out on the bus.

When the window is live, the low bits of the selected bus address choose one of three internal registers: a status register and two input ports. A DMA fetch can therefore land on an input port, or on the status register, only because the processor happened to be touching the window at that moment. In the same way, a sprite copy from the window's page reaches the external bus untouched whenever the processor is elsewhere.

The block returns the read data that results. The status register cuts off the external bus. An input port and a live external driver collide, and the result is their bitwise AND with a conflict flag raised. A window address with no register behind it and no external driver gives back the held open-bus byte. All outputs are registered.

Top module: `dma_regwin_decoder`

## Requirements
- R1: The outgoing address `bus_addr` is the `src_addr` entry named by the one-hot `src_sel`: bit 0 sample fetch, bit 1 processor, bit 2 sprite read, bit 3 sprite write. A `src_sel` that is not exactly one-hot selects the processor address.
- R2: `win_open` is high exactly when the processor address (`src_addr` entry 1) lies in 0x4000–0x401F, whichever source drives the bus.
- R3: With the window open and `bus_rd` high, the selected address ANDed with 0x401F decides the hit. 0x4015 raises `status_stb`, 0x4016 raises `port0_stb` and 0x4017 raises `port1_stb`.
- R4: With the window closed, no strobe and no `ext_iso` is raised, for any bus address, including 0x4015–0x4017. Read data is then `ext_data` when `ext_valid` is high, else the held open-bus byte.
- R5: With the window open and the masked address equal to 0x4015, `ext_iso` is high and `rd_data` is `status_val`, whatever the external bus carries.
- R6: On a port strobe, `rd_data` is the port value ANDed with `ext_data` and `bus_conflict` is high when `ext_valid` is high. Otherwise `rd_data` is the port value alone and `bus_conflict` is low.
- R7: In all other cases, `rd_data` is `ext_data` when `ext_valid` is high, else the open-bus byte. The open-bus byte is the `rd_data` of the most recent cycle with `bus_rd` high, and zero after reset.
- R8: Every output takes the value computed from the inputs of the previous rising clock edge. During reset every output is zero.
- R9: At most one of `status_stb`, `port0_stb` and `port1_stb` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_addr | input | 4x16 | Addresses of sample fetch, processor, sprite read, sprite write |
| src_sel | input | 4 | One-hot bus owner select |
| bus_rd | input | 1 | Current cycle is a read |
| ext_data | input | 8 | Byte driven on the external bus |
| ext_valid | input | 1 | An external device drives `ext_data` |
| status_val | input | 8 | Internal status register value |
| port0_val | input | 8 | Input port 0 value |
| port1_val | input | 8 | Input port 1 value |
| bus_addr | output | 16 | Registered selected address |
| win_open | output | 1 | Registered register-window enable |
| status_stb | output | 1 | Status register read strobe |
| port0_stb | output | 1 | Port 0 read strobe |
| port1_stb | output | 1 | Port 1 read strobe |
| ext_iso | output | 1 | External bus isolated |
| rd_data | output | 8 | Returned read byte |
| bus_conflict | output | 1 | Port byte collided with an external driver |

## Verification
The bench goes after the cases where the bus owner and the processor disagree. A DMA to 0x4016 or 0xXX17 with the processor inside the window must strobe a port. A design that decoded the window from the muxed address would miss this, and it would also wrongly strobe on a sprite copy from page 0x40 while the processor is outside the window. A processor read of 0x4015 must return status even with an external driver present; a design without isolation would return the external byte. Port reads with a live external driver must AND the two bytes and flag the conflict. Undriven window reads must repeat the previous read byte, and an open-bus register that also updated on non-read cycles would give a stale or wrong byte. Zero and multi-bit selects must fall back to the processor address.

// File: rtl/wdec_pkg.sv
package wdec_pkg;

   // Source slots of the address mux, in select-bit order.
   typedef enum logic [1:0] {
      SRC_SAMPLE = 2'd0,
      SRC_CPU    = 2'd1,
      SRC_SPR_RD = 2'd2,
      SRC_SPR_WR = 2'd3
   } src_slot_e;

   // Decode result of one cycle.
   typedef struct packed {
      logic win;     // register window live
      logic iso;     // status address hit, external bus cut off
      logic st;      // status read strobe
      logic p0;      // port 0 read strobe
      logic p1;      // port 1 read strobe
   } hit_t;

endpackage

// File: rtl/wdec_src_mux.sv
module wdec_src_mux #(
   parameter int N_SRC   = 4,
   parameter int ADDR_W  = 16,
   parameter int DEF_IDX = 1
) (
   input  logic [N_SRC-1:0][ADDR_W-1:0] src_addr,
   input  logic [N_SRC-1:0]             src_sel,
   output logic [ADDR_W-1:0]            sel_addr
);

   localparam int CNT_W = $clog2(N_SRC + 1);

   logic [N_SRC-1:0][ADDR_W-1:0] gated;
   logic [ADDR_W-1:0]            or_tree;
   logic [CNT_W-1:0]             n_set;

   // AND each source with its select line.
   for (genvar i = 0; i < N_SRC; i++) begin : g_gate
      assign gated[i] = src_addr[i] & {ADDR_W{src_sel[i]}};
   end

   always_comb begin
      or_tree = '0;
      n_set   = '0;
      for (int i = 0; i < N_SRC; i++) begin
         or_tree = or_tree | gated[i];
         n_set   = n_set + CNT_W'(src_sel[i]);
      end
   end

   // A select that is not one-hot falls back to the default owner.
   assign sel_addr = (n_set == CNT_W'(1)) ? or_tree : src_addr[DEF_IDX];

endmodule

// File: rtl/wdec_win_decode.sv
module wdec_win_decode
   import wdec_pkg::*;
#(
   parameter int              ADDR_W     = 16,
   parameter int              OFS_BITS   = 5,
   parameter logic [15:0]     WIN_BASE   = 16'h4000,
   parameter int              STATUS_OFS = 'h15,
   parameter int              PORT0_OFS  = 'h16,
   parameter int              PORT1_OFS  = 'h17
) (
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   output hit_t              hit
);

   localparam logic [ADDR_W-1:0] BASE    = ADDR_W'(WIN_BASE);
   localparam logic [ADDR_W-1:0] OFS_MSK = ADDR_W'((1 << OFS_BITS) - 1);
   localparam logic [ADDR_W-1:0] DEC_MSK = BASE | OFS_MSK;
   localparam logic [ADDR_W-1:0] ST_KEY  = BASE | ADDR_W'(STATUS_OFS);
   localparam logic [ADDR_W-1:0] P0_KEY  = BASE | ADDR_W'(PORT0_OFS);
   localparam logic [ADDR_W-1:0] P1_KEY  = BASE | ADDR_W'(PORT1_OFS);

   logic              win;
   logic [ADDR_W-1:0] masked;
   logic              st_addr, p0_addr, p1_addr;

   // Window enable looks only at the processor's address.
   assign win     = (cpu_addr >> OFS_BITS) == (BASE >> OFS_BITS);
   // Register hit looks at whatever owns the bus.
   assign masked  = bus_addr & DEC_MSK;
   assign st_addr = masked == ST_KEY;
   assign p0_addr = masked == P0_KEY;
   assign p1_addr = masked == P1_KEY;

   always_comb begin
      hit.win = win;
      hit.iso = win & st_addr;
      hit.st  = win & st_addr & bus_rd;
      hit.p0  = win & p0_addr & bus_rd;
      hit.p1  = win & p1_addr & bus_rd;
   end

endmodule

// File: rtl/wdec_data_merge.sv
module wdec_data_merge
   import wdec_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  hit_t              hit,
   input  logic [DATA_W-1:0] ext_data,
   input  logic              ext_valid,
   input  logic [DATA_W-1:0] status_val,
   input  logic [DATA_W-1:0] port0_val,
   input  logic [DATA_W-1:0] port1_val,
   input  logic [DATA_W-1:0] open_bus,
   output logic [DATA_W-1:0] data,
   output logic              conflict
);

   logic [DATA_W-1:0] port_byte;
   logic              port_hit;

   assign port_hit  = hit.p0 | hit.p1;
   assign port_byte = hit.p0 ? port0_val : port1_val;

   always_comb begin
      conflict = 1'b0;
      if (hit.iso) begin
         data = status_val;
      end else if (port_hit) begin
         // Open-drain style collision: both drivers pull low.
         data     = ext_valid ? (port_byte & ext_data) : port_byte;
         conflict = ext_valid;
      end else begin
         data = ext_valid ? ext_data : open_bus;
      end
   end

endmodule

// File: rtl/dma_regwin_decoder.sv
module dma_regwin_decoder
   import wdec_pkg::*;
#(
   parameter int          N_SRC      = 4,
   parameter int          ADDR_W     = 16,
   parameter int          DATA_W     = 8,
   parameter int          CPU_IDX    = 1,
   parameter int          OFS_BITS   = 5,
   parameter logic [15:0] WIN_BASE   = 16'h4000,
   parameter int          STATUS_OFS = 'h15,
   parameter int          PORT0_OFS  = 'h16,
   parameter int          PORT1_OFS  = 'h17
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [N_SRC-1:0][ADDR_W-1:0] src_addr,
   input  logic [N_SRC-1:0]             src_sel,
   input  logic                         bus_rd,
   input  logic [DATA_W-1:0]            ext_data,
   input  logic                         ext_valid,
   input  logic [DATA_W-1:0]            status_val,
   input  logic [DATA_W-1:0]            port0_val,
   input  logic [DATA_W-1:0]            port1_val,
   output logic [ADDR_W-1:0]            bus_addr,
   output logic                         win_open,
   output logic                         status_stb,
   output logic                         port0_stb,
   output logic                         port1_stb,
   output logic                         ext_iso,
   output logic [DATA_W-1:0]            rd_data,
   output logic                         bus_conflict
);

   localparam int OFS_SPAN = 1 << OFS_BITS;

   // Elaboration-time parameter checks.
   if (N_SRC < 2) begin : g_bad_nsrc
      $error("N_SRC must be at least 2");
   end
   if (CPU_IDX < 0 || CPU_IDX >= N_SRC) begin : g_bad_cpu
      $error("CPU_IDX out of range");
   end
   if (OFS_BITS < 2 || OFS_BITS >= ADDR_W) begin : g_bad_ofs
      $error("OFS_BITS out of range");
   end
   if ((int'(WIN_BASE) % OFS_SPAN) != 0) begin : g_bad_base
      $error("WIN_BASE must be aligned to the window span");
   end
   if (STATUS_OFS >= OFS_SPAN || PORT0_OFS >= OFS_SPAN || PORT1_OFS >= OFS_SPAN) begin : g_bad_key
      $error("register offsets must lie inside the window");
   end
   if (STATUS_OFS == PORT0_OFS || STATUS_OFS == PORT1_OFS || PORT0_OFS == PORT1_OFS) begin : g_dup_key
      $error("register offsets must differ");
   end

   logic [ADDR_W-1:0] sel_addr;
   hit_t              hit;
   logic [DATA_W-1:0] merged;
   logic              merged_conf;
   logic [DATA_W-1:0] open_bus_q;

   wdec_src_mux #(
      .N_SRC  (N_SRC),
      .ADDR_W (ADDR_W),
      .DEF_IDX(CPU_IDX)
   ) u_mux (
      .src_addr(src_addr),
      .src_sel (src_sel),
      .sel_addr(sel_addr)
   );

   wdec_win_decode #(
      .ADDR_W    (ADDR_W),
      .OFS_BITS  (OFS_BITS),
      .WIN_BASE  (WIN_BASE),
      .STATUS_OFS(STATUS_OFS),
      .PORT0_OFS (PORT0_OFS),
      .PORT1_OFS (PORT1_OFS)
   ) u_dec (
      .cpu_addr(src_addr[CPU_IDX]),
      .bus_addr(sel_addr),
      .bus_rd  (bus_rd),
      .hit     (hit)
   );

   wdec_data_merge #(
      .DATA_W(DATA_W)
   ) u_merge (
      .hit       (hit),
      .ext_data  (ext_data),
      .ext_valid (ext_valid),
      .status_val(status_val),
      .port0_val (port0_val),
      .port1_val (port1_val),
      .open_bus  (open_bus_q),
      .data      (merged),
      .conflict  (merged_conf)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_addr     <= '0;
         win_open     <= 1'b0;
         status_stb   <= 1'b0;
         port0_stb    <= 1'b0;
         port1_stb    <= 1'b0;
         ext_iso      <= 1'b0;
         rd_data      <= '0;
         bus_conflict <= 1'b0;
         open_bus_q   <= '0;
      end else begin
         bus_addr     <= sel_addr;
         win_open     <= hit.win;
         status_stb   <= hit.st;
         port0_stb    <= hit.p0;
         port1_stb    <= hit.p1;
         ext_iso      <= hit.iso;
         rd_data      <= merged;
         bus_conflict <= merged_conf;
         if (bus_rd) begin
            open_bus_q <= merged;
         end
      end
   end

endmodule

// File: rtl/wdec_checker.sv
module wdec_checker #(
   parameter int          N_SRC    = 4,
   parameter int          ADDR_W   = 16,
   parameter int          DATA_W   = 8,
   parameter int          CPU_IDX  = 1,
   parameter int          OFS_BITS = 5,
   parameter logic [15:0] WIN_BASE = 16'h4000
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic [N_SRC-1:0][ADDR_W-1:0] src_addr,
   input logic [DATA_W-1:0]            status_val,
   input logic                         win_open,
   input logic                         status_stb,
   input logic                         port0_stb,
   input logic                         port1_stb,
   input logic                         ext_iso,
   input logic [DATA_W-1:0]            rd_data,
   input logic                         bus_conflict
);

   localparam logic [ADDR_W-1:0] BASE = ADDR_W'(WIN_BASE);

   // R9: strobes are mutually exclusive
   a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({status_stb, port0_stb, port1_stb}));

   // R4: closed window gives no strobe and no isolation
   a_r4_closed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !win_open |-> !(status_stb || port0_stb || port1_stb || ext_iso));

   // R2: window follows the processor address of the prior edge
   a_r2_win_from_cpu: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n && $past(rst_n) |->
      (win_open == (($past(src_addr[CPU_IDX]) >> OFS_BITS) == (BASE >> OFS_BITS))));

   // R5: isolation returns the status byte
   a_r5_iso_status: assert property (@(posedge clk) disable iff (!rst_n)
      ext_iso && $past(rst_n) |-> rd_data == $past(status_val));

   // R3: a status strobe only occurs with isolation
   a_r3_status_iso: assert property (@(posedge clk) disable iff (!rst_n)
      status_stb |-> ext_iso);

   // R6: conflict only on a port strobe
   a_r6_conflict_port: assert property (@(posedge clk) disable iff (!rst_n)
      bus_conflict |-> (port0_stb || port1_stb));

endmodule

bind dma_regwin_decoder wdec_checker #(
   .N_SRC   (N_SRC),
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W),
   .CPU_IDX (CPU_IDX),
   .OFS_BITS(OFS_BITS),
   .WIN_BASE(WIN_BASE)
) u_wdec_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .src_addr    (src_addr),
   .status_val  (status_val),
   .win_open    (win_open),
   .status_stb  (status_stb),
   .port0_stb   (port0_stb),
   .port1_stb   (port1_stb),
   .ext_iso     (ext_iso),
   .rd_data     (rd_data),
   .bus_conflict(bus_conflict)
);

// File: tb/dma_regwin_decoder_test.sv
module dma_regwin_decoder_test;

   logic              clk = 1'b0;
   logic              rst_n;
   logic [3:0][15:0]  src_addr;
   logic [3:0]        src_sel;
   logic              bus_rd;
   logic [7:0]        ext_data;
   logic              ext_valid;
   logic [7:0]        status_val, port0_val, port1_val;
   logic [15:0]       bus_addr;
   logic              win_open, status_stb, port0_stb, port1_stb, ext_iso;
   logic [7:0]        rd_data;
   logic              bus_conflict;

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;
   logic [7:0] ob_model;

   always #4 clk = ~clk;

   dma_regwin_decoder uut (
      .clk(clk), .rst_n(rst_n), .src_addr(src_addr), .src_sel(src_sel),
      .bus_rd(bus_rd), .ext_data(ext_data), .ext_valid(ext_valid),
      .status_val(status_val), .port0_val(port0_val), .port1_val(port1_val),
      .bus_addr(bus_addr), .win_open(win_open), .status_stb(status_stb),
      .port0_stb(port0_stb), .port1_stb(port1_stb), .ext_iso(ext_iso),
      .rd_data(rd_data), .bus_conflict(bus_conflict)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] ref_sel(input logic [3:0][15:0] a, input logic [3:0] s);
      case (s)
         4'b0001: return a[0];
         4'b0010: return a[1];
         4'b0100: return a[2];
         4'b1000: return a[3];
         default: return a[1];
      endcase
   endfunction

   function automatic bit ref_win(input logic [15:0] cpu);
      return cpu >= 16'h4000 && cpu <= 16'h401F;
   endfunction

   // Drive one cycle of inputs, then check outputs at the next falling edge.
   task automatic step(input logic [3:0][15:0] a, input logic [3:0] s, input logic rd,
                       input logic [7:0] ed, input logic ev, input logic [7:0] sv,
                       input logic [7:0] p0, input logic [7:0] p1, input string tag);
      logic [15:0] sa, m;
      bit w, st, h0, h1, iso, cf;
      logic [7:0] d;
      src_addr = a; src_sel = s; bus_rd = rd; ext_data = ed; ext_valid = ev;
      status_val = sv; port0_val = p0; port1_val = p1;
      sa  = ref_sel(a, s);
      w   = ref_win(a[1]);
      m   = sa & 16'h401F;
      iso = w && m == 16'h4015;
      st  = iso && rd;
      h0  = w && m == 16'h4016 && rd;
      h1  = w && m == 16'h4017 && rd;
      cf  = 1'b0;
      if (iso) d = sv;
      else if (h0 || h1) begin
         d  = ev ? ((h0 ? p0 : p1) & ed) : (h0 ? p0 : p1);
         cf = ev;
      end else d = ev ? ed : ob_model;
      @(negedge clk);
      chk({"R1 addr ", tag}, 32'(bus_addr), 32'(sa));
      chk({"R2 win ", tag}, 32'(win_open), 32'(w));
      chk({"R3 strobes ", tag}, 32'({status_stb, port0_stb, port1_stb}), 32'({st, h0, h1}));
      chk({"R5 iso ", tag}, 32'(ext_iso), 32'(iso));
      chk({"R7 data ", tag}, 32'(rd_data), 32'(d));
      chk({"R6 conflict ", tag}, 32'(bus_conflict), 32'(cf));
      if (rd) ob_model = d;
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      #1600000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      logic [3:0][15:0] a;
      void'($urandom(32'd4242));
      rst_n = 1'b0; src_addr = '0; src_sel = 4'b0010; bus_rd = 1'b0;
      ext_data = 8'hA5; ext_valid = 1'b1; status_val = 8'h3C;
      port0_val = 8'h0F; port1_val = 8'hF0; ob_model = 8'h00;
      src_addr[1] = 16'h4016; bus_rd = 1'b1;
      repeat (3) @(negedge clk);
      // R8: reset holds every output at zero
      chk("R8 reset addr", 32'(bus_addr), 0);
      chk("R8 reset flags", 32'({win_open, status_stb, port0_stb, port1_stb, ext_iso, bus_conflict}), 0);
      chk("R8 reset data", 32'(rd_data), 0);
      rst_n = 1'b1;

      // R3: sample DMA to 0x4016 while processor sits in window
      a = '{16'h1234, 16'h4017, 16'h0200, 16'hC016};
      a[0] = 16'hC016; a[1] = 16'h4017; a[2] = 16'h0200; a[3] = 16'h2004;
      step(a, 4'b0001, 1'b1, 8'h77, 1'b0, 8'h11, 8'h5A, 8'hA5, "dma hits port0");
      // R6: same with an external driver present -> AND and conflict
      step(a, 4'b0001, 1'b1, 8'h3C, 1'b1, 8'h11, 8'h5A, 8'hA5, "dma conflict");
      // R4: same DMA address, processor outside window
      a[1] = 16'h8000;
      step(a, 4'b0001, 1'b1, 8'h66, 1'b1, 8'h11, 8'h5A, 8'hA5, "dma miss cpu out");
      // R4: sprite copy of page 0x40 with processor outside window
      for (int i = 16'h14; i < 16'h18; i++) begin
         a[2] = 16'h4000 | 16'(i);
         step(a, 4'b0100, 1'b1, 8'(i + 8'h80), 1'b1, 8'h22, 8'h01, 8'h02, "sprite page40");
      end
      // R5: processor reads status, external bus ignored
      a[1] = 16'h4015;
      step(a, 4'b0010, 1'b1, 8'hFF, 1'b1, 8'h9C, 8'h01, 8'h02, "cpu status");
      // R7: undriven window address returns open bus (last read = 0x9C)
      a[1] = 16'h4003;
      step(a, 4'b0010, 1'b1, 8'h00, 1'b0, 8'h9C, 8'h01, 8'h02, "open bus");
      // R7: non-read cycle does not refresh open bus
      step(a, 4'b0010, 1'b0, 8'h44, 1'b1, 8'h9C, 8'h01, 8'h02, "write no ob");
      step(a, 4'b0010, 1'b1, 8'h00, 1'b0, 8'h9C, 8'h01, 8'h02, "ob held");
      // R1: zero and multi-bit selects fall back to processor
      a[0] = 16'h1111; a[1] = 16'h2222; a[2] = 16'h3333; a[3] = 16'h4444;
      step(a, 4'b0000, 1'b0, 8'h00, 1'b1, 8'h00, 8'h00, 8'h00, "sel zero");
      step(a, 4'b0101, 1'b0, 8'h00, 1'b1, 8'h00, 8'h00, 8'h00, "sel multi");
      step(a, 4'b1000, 1'b0, 8'h00, 1'b1, 8'h00, 8'h00, 8'h00, "sel sprite wr");
      // R3: port1 via high page mirror with processor in window
      a[1] = 16'h401F; a[0] = 16'hFF17;
      step(a, 4'b0001, 1'b1, 8'h00, 1'b0, 8'h00, 8'h00, 8'hC3, "mirror port1");

      // Constrained random mix (R1-R9 coverage)
      for (int n = 0; n < 3000; n++) begin
         logic [3:0] s;
         for (int k = 0; k < 4; k++) begin
            case ($urandom_range(2))
               0: a[k] = 16'h4000 | 16'($urandom_range(31));
               1: a[k] = {8'($urandom), 3'b000, 5'($urandom_range(16'h14, 16'h17))};
               default: a[k] = 16'($urandom);
            endcase
         end
         s = ($urandom_range(7) == 0) ? 4'($urandom) : 4'(1 << $urandom_range(3));
         step(a, s, 1'($urandom), 8'($urandom), 1'($urandom), 8'($urandom),
              8'($urandom), 8'($urandom), "random");
      end
      done = 1'b1;
      finish_run();
   end

endmodule